// File: doc/BRIEF.md
# Time-Slot Power-Up Sequencer

This block brings up to four downstream DC-DC converters in a set order once the main pass device has charged the load. Each converter enable is an open-drain pin. The block drives the pull-down control for each pin. Each output is assigned to one of four ordered time slots. A slot may hold any number of outputs, including none. Slot 0 starts when the load is judged fully powered, and each later slot follows after a programmable number of clock cycles.

The "load fully powered" judgement combines two comparator flags. The first is a gate-good flag, which is latched the first time it is seen. The second is a drain-sense-low flag. The drain-sense check is waived while the external current-regulation loop reports that it is active. Dropping the sequence enable returns all outputs to their inactive level, clears the gate-good latch and sends the controller back to waiting.

Top module: `pwrseq_slot_top`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls with `seq_en` low, the outputs read: `waiting`=1, `done`=0, `slot_idx`=0, and every output inactive (`pull_dn` equal to `pol`).
- R2: Slot 0 does not begin while the drain-sense flag is low and current regulation is inactive, even with the gate-good flag high.
- R3: Once `gate_good` is seen high with `seq_en` high, the gate condition stays met after `gate_good` falls. A later drain-sense-low alone then starts slot 0 on the next clock edge.
- R4: While `creg_active` is high, the drain-sense flag is ignored. Gate-good alone then starts slot 0.
- R5: Slot k+1 begins exactly max(`interval`,1) clock cycles after slot k begins. `slot_idx` only steps up by one and holds at 3.
- R6: Output i uses slot field `slot_map[2i+1:2i]`. Output A is i=0 and output D is i=3. The output asserts on the cycle its slot begins and stays asserted until the sequence is reset.
- R7: When `pol[i]`=1 the output is active-high: asserted means released (`pull_dn[i]`=0) and inactive means pulled low (`pull_dn[i]`=1). When `pol[i]`=0 the output is active-low: asserted means `pull_dn[i]`=1 and inactive means `pull_dn[i]`=0.
- R8: When `seq_en` is sampled low, the next cycle shows `waiting`=1, `done`=0, `slot_idx`=0 and all outputs inactive. The gate-good latch is cleared, so a later start needs `gate_good` again.
- R9: `done` rises on the same cycle that slot 3 begins and is only ever high with `slot_idx`=3.
- R10: No slot begins while `seq_en` is low, whatever the power-good flags are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seq_en | input | 1 | Sequence enable; low resets the sequence |
| drain_low | input | 1 | Drain-sense comparator below threshold |
| gate_good | input | 1 | Gate voltage above its enhancement threshold |
| creg_active | input | 1 | Current regulation loop active; masks drain-sense |
| slot_map | input | 8 | Two-bit slot number per output, output A in bits [1:0] |
| pol | input | 4 | Per-output polarity, 1 = active-high |
| interval | input | 16 | Slot spacing in clock cycles (0 acts as 1) |
| pull_dn | output | 4 | Open-drain pull-down controls, 1 = pull low |
| slot_idx | output | 2 | Index of the latest slot that has begun |
| waiting | output | 1 | Waiting for the load to be powered |
| done | output | 1 | Slot 3 has begun |

## Verification
The hardest case to reach is a start that depends on remembered state. One form is a gate-good pulse that has long since vanished, combined with a drain-sense flag that arrives later. The other is the same gate pulse once it has been wiped by a short drop of `seq_en`. Directed steps build both orderings and a start masked by current regulation. Randomised runs toggle the three flags independently per cycle and drop the enable now and then, which covers many latch/clear interleavings. Slot spacings of 0 and 1 are included so that slot edges fall on back-to-back cycles.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    typedef enum logic {
        SEQ_WAIT = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_mode_e;

    // Pull-down control for an open-drain pin: active-high outputs are
    // released when asserted, active-low outputs are pulled down.
    function automatic logic pad_pull(input logic asserted, input logic active_high);
        return asserted ^ active_high;
    endfunction

    // Last cycle of a slot with a given spacing; spacing zero behaves as one.
    function automatic logic slot_expired(input logic [15:0] cnt, input logic [15:0] spacing);
        return (spacing == 16'd0) || (cnt >= spacing - 16'd1);
    endfunction

endpackage

// File: rtl/pwrseq_pg_qual.sv
module pwrseq_pg_qual (
    input  logic clk,
    input  logic rst,
    input  logic seq_en,
    input  logic drain_low,
    input  logic gate_good,
    input  logic creg_active,
    output logic pg_ok
);
    logic gate_seen_q;
    logic gate_met;
    logic drain_met;

    always_ff @(posedge clk) begin
        if (rst || !seq_en) begin
            gate_seen_q <= 1'b0;
        end else if (gate_good) begin
            gate_seen_q <= 1'b1;
        end
    end

    always_comb begin
        gate_met  = gate_good | gate_seen_q;
        drain_met = drain_low | creg_active;
        pg_ok     = seq_en & gate_met & drain_met;
    end
endmodule

// File: rtl/pwrseq_slot_fsm.sv
module pwrseq_slot_fsm
    import pwrseq_pkg::*;
#(
    parameter int NUM_SLOT = 4,
    parameter int CNT_W    = 16,
    localparam int SLOT_W  = $clog2(NUM_SLOT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              seq_en,
    input  logic              pg_ok,
    input  logic [CNT_W-1:0]  interval,
    output logic [NUM_SLOT-1:0] slot_begun,
    output logic [SLOT_W-1:0] slot_idx,
    output logic              waiting
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOT - 1);

    typedef struct packed {
        seq_mode_e         mode;
        logic [SLOT_W-1:0] slot;
        logic [CNT_W-1:0]  cnt;
    } seq_state_t;

    seq_state_t        st_q;
    logic              tick_end;
    logic [SLOT_W-1:0] next_slot;

    always_comb begin
        tick_end  = slot_expired(16'(st_q.cnt), 16'(interval));
        next_slot = st_q.slot + SLOT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst || !seq_en) begin
            st_q       <= '{mode: SEQ_WAIT, slot: '0, cnt: '0};
            slot_begun <= '0;
        end else begin
            case (st_q.mode)
                SEQ_WAIT: begin
                    if (pg_ok) begin
                        st_q       <= '{mode: SEQ_RUN, slot: '0, cnt: '0};
                        slot_begun <= NUM_SLOT'(1);
                    end
                end
                SEQ_RUN: begin
                    if (st_q.slot != LAST_SLOT) begin
                        if (tick_end) begin
                            st_q.slot             <= next_slot;
                            st_q.cnt              <= '0;
                            slot_begun[next_slot] <= 1'b1;
                        end else begin
                            st_q.cnt <= st_q.cnt + CNT_W'(1);
                        end
                    end
                end
                default: st_q <= '{mode: SEQ_WAIT, slot: '0, cnt: '0};
            endcase
        end
    end

    assign slot_idx = st_q.slot;
    assign waiting  = (st_q.mode == SEQ_WAIT);
endmodule

// File: rtl/pwrseq_drive.sv
module pwrseq_drive
    import pwrseq_pkg::*;
#(
    parameter int NUM_OUT  = 4,
    parameter int NUM_SLOT = 4,
    localparam int SLOT_W  = $clog2(NUM_SLOT),
    localparam int MAP_W   = NUM_OUT * SLOT_W
) (
    input  logic [MAP_W-1:0]    slot_map,
    input  logic [NUM_OUT-1:0]  pol,
    input  logic [NUM_SLOT-1:0] slot_begun,
    output logic [NUM_OUT-1:0]  pull_dn
);
    for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
        logic [SLOT_W-1:0] field;
        logic              asserted;
        always_comb begin
            field      = slot_map[i*SLOT_W +: SLOT_W];
            asserted   = slot_begun[field];
            pull_dn[i] = pad_pull(asserted, pol[i]);
        end
    end
endmodule

// File: rtl/pwrseq_slot_top.sv
module pwrseq_slot_top #(
    parameter int NUM_OUT  = 4,
    parameter int NUM_SLOT = 4,
    parameter int CNT_W    = 16,
    localparam int SLOT_W  = $clog2(NUM_SLOT),
    localparam int MAP_W   = NUM_OUT * SLOT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               seq_en,
    input  logic               drain_low,
    input  logic               gate_good,
    input  logic               creg_active,
    input  logic [MAP_W-1:0]   slot_map,
    input  logic [NUM_OUT-1:0] pol,
    input  logic [CNT_W-1:0]   interval,
    output logic [NUM_OUT-1:0] pull_dn,
    output logic [SLOT_W-1:0]  slot_idx,
    output logic               waiting,
    output logic               done
);
    logic                pg_ok;
    logic [NUM_SLOT-1:0] slot_begun;

    pwrseq_pg_qual qual_i (
        .clk         (clk),
        .rst         (rst),
        .seq_en      (seq_en),
        .drain_low   (drain_low),
        .gate_good   (gate_good),
        .creg_active (creg_active),
        .pg_ok       (pg_ok)
    );

    pwrseq_slot_fsm #(
        .NUM_SLOT (NUM_SLOT),
        .CNT_W    (CNT_W)
    ) fsm_i (
        .clk        (clk),
        .rst        (rst),
        .seq_en     (seq_en),
        .pg_ok      (pg_ok),
        .interval   (interval),
        .slot_begun (slot_begun),
        .slot_idx   (slot_idx),
        .waiting    (waiting)
    );

    pwrseq_drive #(
        .NUM_OUT  (NUM_OUT),
        .NUM_SLOT (NUM_SLOT)
    ) drive_i (
        .slot_map   (slot_map),
        .pol        (pol),
        .slot_begun (slot_begun),
        .pull_dn    (pull_dn)
    );

    assign done = slot_begun[NUM_SLOT-1];
endmodule

// File: rtl/pwrseq_checker.sv
module pwrseq_checker #(
    parameter int NUM_OUT  = 4,
    parameter int NUM_SLOT = 4,
    parameter int CNT_W    = 16,
    localparam int SLOT_W  = $clog2(NUM_SLOT),
    localparam int MAP_W   = NUM_OUT * SLOT_W
) (
    input logic               clk,
    input logic               rst,
    input logic               seq_en,
    input logic               drain_low,
    input logic               gate_good,
    input logic               creg_active,
    input logic [MAP_W-1:0]   slot_map,
    input logic [NUM_OUT-1:0] pol,
    input logic [CNT_W-1:0]   interval,
    input logic [NUM_OUT-1:0] pull_dn,
    input logic [SLOT_W-1:0]  slot_idx,
    input logic               waiting,
    input logic               done
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOT - 1);

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (waiting && !done && slot_idx == '0));

    assert_no_start_drain_high_R2: assert property (@(posedge clk) disable iff (rst)
        (waiting && !drain_low && !creg_active) |=> waiting);

    assert_slot_step_R5: assert property (@(posedge clk) disable iff (rst)
        (seq_en && !waiting && slot_idx != LAST_SLOT)
        |=> (slot_idx == $past(slot_idx) || slot_idx == $past(slot_idx) + SLOT_W'(1)));

    assert_idle_inactive_R7: assert property (@(posedge clk) disable iff (rst)
        waiting |-> (pull_dn == pol));

    assert_enable_drop_R8: assert property (@(posedge clk) disable iff (rst)
        !seq_en |=> (waiting && !done && slot_idx == '0));

    assert_done_last_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> (slot_idx == LAST_SLOT));
endmodule

bind pwrseq_slot_top pwrseq_checker #(
    .NUM_OUT  (NUM_OUT),
    .NUM_SLOT (NUM_SLOT),
    .CNT_W    (CNT_W)
) chk_i (.*);

// File: tb/pwrseq_slot_top_tb_top.sv
`timescale 1ns/1ps
module pwrseq_slot_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        seq_en = 1'b0;
    logic        drain_low = 1'b0;
    logic        gate_good = 1'b0;
    logic        creg_active = 1'b0;
    logic [7:0]  slot_map = 8'hE4;
    logic [3:0]  pol = 4'b0101;
    logic [15:0] interval = 16'd3;
    logic [3:0]  pull_dn;
    logic [1:0]  slot_idx;
    logic        waiting;
    logic        done;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    pwrseq_slot_top dut_i (
        .clk(clk), .rst(rst), .seq_en(seq_en), .drain_low(drain_low),
        .gate_good(gate_good), .creg_active(creg_active), .slot_map(slot_map),
        .pol(pol), .interval(interval), .pull_dn(pull_dn), .slot_idx(slot_idx),
        .waiting(waiting), .done(done)
    );

    // Reference model built from the requirements
    logic m_wait = 1'b1;
    logic m_latch = 1'b0;
    int   m_el = 0;

    always @(posedge clk) begin
        if (rst || !seq_en) begin
            m_wait  <= 1'b1;
            m_latch <= 1'b0;
            m_el    <= 0;
        end else if (m_wait) begin
            if (gate_good) m_latch <= 1'b1;
            if ((gate_good || m_latch) && (drain_low || creg_active)) begin
                m_wait <= 1'b0;
                m_el   <= 0;
            end
        end else if (m_el < 1000000) begin
            m_el <= m_el + 1;
        end
    end

    function automatic int exp_slot();
        int n;
        int s;
        if (m_wait) return 0;
        n = (interval == 16'd0) ? 1 : int'(interval);
        s = m_el / n;
        return (s > 3) ? 3 : s;
    endfunction

    function automatic logic [3:0] exp_pull();
        logic [3:0] r;
        for (int i = 0; i < 4; i++) begin
            logic a;
            a = !m_wait && (int'(slot_map[2*i +: 2]) <= exp_slot());
            r[i] = a ^ pol[i];
        end
        return r;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic compare();
        chk("R2 waiting flag", int'(waiting), int'(m_wait));
        chk("R5 slot index", int'(slot_idx), exp_slot());
        chk("R9 done flag", int'(done), int'(!m_wait && exp_slot() == 3));
        chk("R6 R7 pull-down pattern", int'(pull_dn), int'(exp_pull()));
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 waiting in reset", int'(waiting), 1);
        chk("R1 done in reset", int'(done), 0);
        chk("R1 outputs inactive", int'(pull_dn), int'(pol));
        rst = 1'b0;
        tick();
        chk("R1 idle after reset", int'(waiting), 1);

        // R10: good flags without enable
        gate_good = 1'b1; drain_low = 1'b1;
        ticks(4);
        chk("R10 no start while disabled", int'(waiting), 1);

        // R2: gate good, drain high, no regulation
        gate_good = 1'b1; drain_low = 1'b0; seq_en = 1'b1;
        ticks(5);
        chk("R2 held by drain sense", int'(waiting), 1);

        // R3: latch remembers earlier gate pulse
        gate_good = 1'b0;
        ticks(3);
        drain_low = 1'b1;
        tick();
        chk("R3 start via held gate latch", int'(waiting), 0);
        slot_map = 8'b00_01_10_11; pol = 4'b1100; interval = 16'd2;
        ticks(8);
        chk("R9 done after last slot", int'(done), 1);

        // R8: drop enable clears latch
        seq_en = 1'b0; drain_low = 1'b0;
        tick();
        chk("R8 waiting after disable", int'(waiting), 1);
        chk("R8 outputs inactive", int'(pull_dn), int'(pol));
        seq_en = 1'b1; drain_low = 1'b1;
        ticks(4);
        chk("R8 latch cleared", int'(waiting), 1);

        // R4: regulation masks drain sense
        drain_low = 1'b0; creg_active = 1'b1; gate_good = 1'b1;
        tick();
        chk("R4 start under regulation", int'(waiting), 0);
        creg_active = 1'b0;
        ticks(10);

        // R5: interval zero gives back-to-back slots
        seq_en = 1'b0; tick();
        interval = 16'd0; slot_map = 8'b11_10_01_00; pol = 4'b0000;
        seq_en = 1'b1; drain_low = 1'b1; gate_good = 1'b1;
        tick();
        chk("R5 slot0 begun", int'(slot_idx), 0);
        tick();
        chk("R5 slot1 next cycle", int'(slot_idx), 1);
        ticks(2);
        chk("R9 done at interval zero", int'(done), 1);
        chk("R6 all asserted active-low", int'(pull_dn), 15);

        // Random scenarios
        for (int sc = 0; sc < 60; sc++) begin
            seq_en = 1'b0;
            tick();
            slot_map = 8'($urandom);
            pol      = 4'($urandom);
            interval = 16'($urandom_range(0, 9));
            seq_en   = 1'b1;
            for (int c = 0; c < 50; c++) begin
                gate_good   = ($urandom_range(0, 99) < 25);
                drain_low   = ($urandom_range(0, 99) < 55);
                creg_active = ($urandom_range(0, 99) < 15);
                seq_en      = ($urandom_range(0, 99) < 97);
                tick();
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule